// File: doc/BRIEF.md
# Eight-bit external bus cycle sequencer with prefetch queue

This block produces, clock by clock, the external bus activity of a processor interface with an 8-bit data path and a 20-bit address. It runs its own code prefetch from a sequential fetch pointer into a small byte queue. It also accepts single data reads and writes from the execution side, each tagged with the segment register that formed its address. Every clock it reports the T-state, the address-latch pulse, the latched address, the segment tag, the read, early-write and write strobes, the bus status code and the data on the bus. It also reports which queue byte, if any, the execution side consumed.

The execution side holds a data request until the block pulses completion in T3, where read data is returned. Instruction bytes leave the queue through a take input that also says whether the byte opens a new instruction. A flush input empties the queue, discards any fetch still on the bus and restarts prefetch at a new address. The output fields are meant to be compared one-for-one against a recorded hardware bus trace.

Top module: `bus_seq_top`

## Requirements
- R1: A bus cycle runs T1, T2, T3, T4 on consecutive clocks. A clock with no cycle is Ti, with status passive, segment none and no strobe. The T-state encoding is Ti=0, T1=1, T2=2, T3=3, T4=4.
- R2: The address-latch pulse is high only in T1, and the address output takes the cycle's 20-bit address in T1. That address then holds through T2 to T4 and any following Ti clocks until the next T1.
- R3: The bus status is the cycle code in T1 and T2 and passive in T3, T4 and Ti. The codes are passive=0, code fetch=1, memory read=2 and memory write=3.
- R4: For code fetches and reads, the read strobe is high in T2 and T3 only. In T3 the memory byte appears on the bus data output. For a read, completion pulses in T3 with that byte on the read-data output.
- R5: For writes, the early-write strobe is high in T2 and T3 and the write strobe in T3 only. The write byte is on the bus data output in T3, and completion pulses in T3.
- R6: The segment output is none (0) in T1 and Ti. In T2 to T4 it is CS (3) for code fetches, or the request's own tag for data cycles. The tag encoding is ES=1, SS=2, CS=3, DS=4.
- R7: When a take is asserted and the queue holds a byte, the queue status is first (1) or subsequent (2), chosen by the take-first input. The oldest byte appears on the queue-byte output in that same clock. Otherwise the status is none (0) and the byte is 0.
- R8: A data request that arrives during a code fetch waits until that fetch's T4. When a cycle is chosen, a pending data request wins over prefetch, and the fetch follows on the next T1.
- R9: Prefetch reads consecutive addresses, wrapping from 0xFFFFF to 0x00000. The queue keeps bytes in order. Fetching stops once the queue holds 4 bytes, and a new fetch starts in the clock after a byte is removed.
- R10: A flush empties the queue and loads the fetch pointer. A fetch already on the bus still runs to T4, but its byte is dropped. A flush seen in T4 or Ti gives one Ti before the first fetch at the new address.
- R11: After reset the state is Ti with passive status, no strobes, address 0 and an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty queue and restart prefetch |
| flush_addr_i | input | 20 | New fetch address on flush |
| dreq_valid_i | input | 1 | Data request pending, held until completion |
| dreq_write_i | input | 1 | 1 = write, 0 = read |
| dreq_seg_i | input | 3 | Segment tag of the data request |
| dreq_addr_i | input | 20 | Physical address of the data request |
| dreq_wdata_i | input | 8 | Write byte |
| dreq_done_o | output | 1 | Data cycle completion, high in T3 |
| rdata_o | output | 8 | Read byte, valid with completion of a read |
| take_i | input | 1 | Execution side removes a queue byte |
| take_first_i | input | 1 | Removed byte opens an instruction |
| qstat_o | output | 2 | Queue status of this clock |
| qbyte_o | output | 8 | Byte removed this clock |
| mem_rdata_i | input | 8 | Byte from memory for the current address |
| ale_o | output | 1 | Address latch pulse |
| addr_o | output | 20 | Latched address |
| seg_o | output | 3 | Segment status |
| rd_o | output | 1 | Read strobe |
| awr_o | output | 1 | Early-write strobe |
| wr_o | output | 1 | Write strobe |
| bus_stat_o | output | 2 | Bus status code |
| bus_data_o | output | 8 | Data on the bus |
| tstate_o | output | 3 | Current T-state |

## Verification
On every cycle, the assertions check that T1 to T4 advance in order, that the latch pulse and segment tag fall only in their allowed states, and that status is passive outside T1 and T2. They also check that the address holds between cycles, that the write strobe never appears without the early-write strobe and that the queue is never pushed when full. Only the bench scenarios can show the values themselves. These are the exact fetch addresses across the 20-bit wrap, byte order through the queue, a data read waiting behind a fetch and then beating prefetch, the dropped byte of a flushed fetch, the write data timing, and the clock in which prefetch stops and resumes.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    typedef enum logic [2:0] {
        TS_I = 3'd0,
        TS_1 = 3'd1,
        TS_2 = 3'd2,
        TS_3 = 3'd3,
        TS_4 = 3'd4
    } tstate_e;

    typedef enum logic [1:0] {
        ST_PASV = 2'd0,
        ST_CODE = 2'd1,
        ST_MEMR = 2'd2,
        ST_MEMW = 2'd3
    } bstat_e;

    typedef enum logic [2:0] {
        SG_NONE = 3'd0,
        SG_ES   = 3'd1,
        SG_SS   = 3'd2,
        SG_CS   = 3'd3,
        SG_DS   = 3'd4
    } seg_e;

    typedef enum logic [1:0] {
        K_FETCH = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        QS_NONE  = 2'd0,
        QS_FIRST = 2'd1,
        QS_SUBS  = 2'd2
    } qstat_e;

endpackage

// File: rtl/bus_seq_queue.sv
module bus_seq_queue #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CW-1:0]     count_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [IW-1:0]                rd;
        logic [IW-1:0]                wr;
        logic [CW-1:0]                cnt;
    } q_t;

    q_t q_d, q_q;
    logic do_push, do_pop;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
        return (i == IW'(DEPTH - 1)) ? '0 : i + IW'(1);
    endfunction

    always_comb begin
        q_d     = q_q;
        do_pop  = pop_i && (q_q.cnt != '0);
        do_push = push_i && (q_q.cnt != CW'(DEPTH));
        if (flush_i) begin
            q_d.rd  = '0;
            q_d.wr  = '0;
            q_d.cnt = '0;
        end else begin
            if (do_push) begin
                q_d.mem[q_q.wr] = push_data_i;
                q_d.wr          = step(q_q.wr);
            end
            if (do_pop) begin
                q_d.rd = step(q_q.rd);
            end
            q_d.cnt = q_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_o  = q_q.mem[q_q.rd];
    assign count_o = q_q.cnt;

    assert_push_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (q_q.cnt < CW'(DEPTH)));

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CW'(DEPTH));

endmodule

// File: rtl/bus_seq_decode.sv
module bus_seq_decode
    import bus_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  tstate_e           ts_i,
    input  kind_e             kind_i,
    input  seg_e              seg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              ale_o,
    output seg_e              seg_o,
    output logic              rd_o,
    output logic              awr_o,
    output logic              wr_o,
    output bstat_e            stat_o,
    output logic [DATA_W-1:0] data_o
);

    logic early, strobe_win, is_wr;

    always_comb begin
        early      = (ts_i == TS_1) || (ts_i == TS_2);
        strobe_win = (ts_i == TS_2) || (ts_i == TS_3);
        is_wr      = (kind_i == K_WRITE);

        ale_o = (ts_i == TS_1);
        seg_o = (strobe_win || ts_i == TS_4) ? seg_i : SG_NONE;
        rd_o  = strobe_win && !is_wr;
        awr_o = strobe_win && is_wr;
        wr_o  = (ts_i == TS_3) && is_wr;

        stat_o = ST_PASV;
        if (early) begin
            unique case (kind_i)
                K_READ:  stat_o = ST_MEMR;
                K_WRITE: stat_o = ST_MEMW;
                default: stat_o = ST_CODE;
            endcase
        end

        data_o = '0;
        if (ts_i == TS_3) data_o = is_wr ? wdata_i : mem_rdata_i;
    end

endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int QDEPTH = 4,
    localparam int CW    = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_addr_i,
    input  logic              dreq_valid_i,
    input  logic              dreq_write_i,
    input  logic [2:0]        dreq_seg_i,
    input  logic [ADDR_W-1:0] dreq_addr_i,
    input  logic [DATA_W-1:0] dreq_wdata_i,
    output logic              dreq_done_o,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              take_i,
    input  logic              take_first_i,
    output logic [1:0]        qstat_o,
    output logic [DATA_W-1:0] qbyte_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              ale_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [2:0]        seg_o,
    output logic              rd_o,
    output logic              awr_o,
    output logic              wr_o,
    output logic [1:0]        bus_stat_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic [2:0]        tstate_o
);

    typedef struct packed {
        tstate_e           ts;
        kind_e             kind;
        seg_e              seg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [ADDR_W-1:0] ptr;
        logic              discard;
    } st_t;

    st_t st_d, st_q;

    logic [DATA_W-1:0] q_head;
    logic [CW-1:0]     q_cnt;
    logic              q_push;
    logic              q_has;

    seg_e   dec_seg;
    bstat_e dec_stat;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ts)
            TS_1: st_d.ts = TS_2;
            TS_2: st_d.ts = TS_3;
            TS_3: st_d.ts = TS_4;
            default: begin
                st_d.discard = 1'b0;
                if (flush_i) begin
                    st_d.ts = TS_I;
                end else if (dreq_valid_i) begin
                    st_d.ts    = TS_1;
                    st_d.kind  = dreq_write_i ? K_WRITE : K_READ;
                    st_d.seg   = seg_e'(dreq_seg_i);
                    st_d.addr  = dreq_addr_i;
                    st_d.wdata = dreq_wdata_i;
                end else if (q_cnt < CW'(QDEPTH)) begin
                    st_d.ts   = TS_1;
                    st_d.kind = K_FETCH;
                    st_d.seg  = SG_CS;
                    st_d.addr = st_q.ptr;
                    st_d.ptr  = st_q.ptr + ADDR_W'(1);
                end else begin
                    st_d.ts = TS_I;
                end
            end
        endcase
        if (flush_i) begin
            st_d.ptr = flush_addr_i;
            if (st_q.kind == K_FETCH && (st_q.ts == TS_1 || st_q.ts == TS_2))
                st_d.discard = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.ts      <= TS_I;
            st_q.kind    <= K_FETCH;
            st_q.seg     <= SG_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_push = (st_q.ts == TS_3) && (st_q.kind == K_FETCH) && !st_q.discard;
    assign q_has  = (q_cnt != '0);

    bus_seq_queue #(
        .DEPTH  (QDEPTH),
        .DATA_W (DATA_W)
    ) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .push_i      (q_push),
        .push_data_i (mem_rdata_i),
        .pop_i       (take_i),
        .head_o      (q_head),
        .count_o     (q_cnt)
    );

    bus_seq_decode #(
        .DATA_W (DATA_W)
    ) u_decode (
        .ts_i        (st_q.ts),
        .kind_i      (st_q.kind),
        .seg_i       (st_q.seg),
        .wdata_i     (st_q.wdata),
        .mem_rdata_i (mem_rdata_i),
        .ale_o       (ale_o),
        .seg_o       (dec_seg),
        .rd_o        (rd_o),
        .awr_o       (awr_o),
        .wr_o        (wr_o),
        .stat_o      (dec_stat),
        .data_o      (bus_data_o)
    );

    assign seg_o      = dec_seg;
    assign bus_stat_o = dec_stat;
    assign tstate_o   = st_q.ts;
    assign addr_o     = st_q.addr;

    assign dreq_done_o = (st_q.ts == TS_3) && (st_q.kind != K_FETCH);
    assign rdata_o     = (dreq_done_o && st_q.kind == K_READ) ? mem_rdata_i : '0;

    always_comb begin
        qstat_o = QS_NONE;
        qbyte_o = '0;
        if (take_i && q_has) begin
            qstat_o = take_first_i ? QS_FIRST : QS_SUBS;
            qbyte_o = q_head;
        end
    end

    assert_t1_to_t2_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate_o == TS_1) |=> (tstate_o == TS_2));
    assert_t2_to_t3_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate_o == TS_2) |=> (tstate_o == TS_3));
    assert_t3_to_t4_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate_o == TS_3) |=> (tstate_o == TS_4));
    assert_t4_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate_o == TS_4) |=> (tstate_o == TS_1 || tstate_o == TS_I));

    assert_ale_in_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> (tstate_o == TS_1));
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_d.ts != TS_1) |=> $stable(addr_o));

    assert_late_passive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate_o == TS_3 || tstate_o == TS_4 || tstate_o == TS_I) |-> (bus_stat_o == ST_PASV));

    assert_rd_wr_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && awr_o));
    assert_wr_inside_awr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> awr_o);

    assert_seg_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_o != SG_NONE) |-> (tstate_o == TS_2 || tstate_o == TS_3 || tstate_o == TS_4));

    assert_qbyte_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (qstat_o == QS_NONE) |-> (qbyte_o == '0));

endmodule

// File: tb/bus_seq_top_bench.sv
module bus_seq_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [19:0] flush_addr_i = '0;
    logic        dreq_valid_i = 1'b0;
    logic        dreq_write_i = 1'b0;
    logic [2:0]  dreq_seg_i = '0;
    logic [19:0] dreq_addr_i = '0;
    logic [7:0]  dreq_wdata_i = '0;
    logic        take_i = 1'b0;
    logic        take_first_i = 1'b0;
    logic        dreq_done_o;
    logic [7:0]  rdata_o;
    logic [1:0]  qstat_o;
    logic [7:0]  qbyte_o;
    logic [7:0]  mem_rdata_i;
    logic        ale_o;
    logic [19:0] addr_o;
    logic [2:0]  seg_o;
    logic        rd_o, awr_o, wr_o;
    logic [1:0]  bus_stat_o;
    logic [7:0]  bus_data_o;
    logic [2:0]  tstate_o;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mb(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'hA5;
    endfunction

    assign mem_rdata_i = mb(addr_o);

    bus_seq_top u_bus_seq_top (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
        .dreq_valid_i(dreq_valid_i), .dreq_write_i(dreq_write_i), .dreq_seg_i(dreq_seg_i),
        .dreq_addr_i(dreq_addr_i), .dreq_wdata_i(dreq_wdata_i), .dreq_done_o(dreq_done_o),
        .rdata_o(rdata_o), .take_i(take_i), .take_first_i(take_first_i), .qstat_o(qstat_o),
        .qbyte_o(qbyte_o), .mem_rdata_i(mem_rdata_i), .ale_o(ale_o), .addr_o(addr_o),
        .seg_o(seg_o), .rd_o(rd_o), .awr_o(awr_o), .wr_o(wr_o), .bus_stat_o(bus_stat_o),
        .bus_data_o(bus_data_o), .tstate_o(tstate_o)
    );

    function automatic logic [31:0] tx(input logic ale, input logic [19:0] a, input logic [2:0] sg,
                                       input logic rd, input logic aw, input logic w,
                                       input logic [1:0] st, input logic [2:0] ts);
        return {ale, a, sg, rd, aw, w, st, ts};
    endfunction

    // kind: 0 fetch, 1 read, 2 write; p: 0..3 for T1..T4
    function automatic logic [31:0] cyc(input int kind, input logic [19:0] a, input logic [2:0] sg, input int p);
        logic mid = (p == 1) || (p == 2);
        return tx(p == 0, a, (p == 0) ? 3'd0 : sg, (kind != 2) && mid, (kind == 2) && mid,
                  (kind == 2) && (p == 2), (p < 2) ? 2'(kind + 1) : 2'd0, 3'(p + 1));
    endfunction

    function automatic logic [31:0] obs();
        return {ale_o, addr_o, seg_o, rd_o, awr_o, wr_o, bus_stat_o, tstate_o};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual running expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    localparam logic [19:0] A = 20'hFFFFE;
    localparam logic [19:0] B = 20'h12340;
    localparam logic [19:0] D = 20'h0ABCD;
    localparam logic [19:0] W = 20'h54321;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        take_i = 1'b1;
        #1;
        // R11 reset state, R7 empty queue take ignored
        chk("R11", obs(), tx(0, 20'h0, 3'd0, 0, 0, 0, 2'd0, 3'd0));
        chk("R7", {22'd0, qstat_o, qbyte_o}, 32'd0);
        take_i = 1'b0;
        flush_i = 1'b1;
        flush_addr_i = A;
        tick();
        flush_i = 1'b0;
        chk("R10", obs(), tx(0, 20'h0, 3'd0, 0, 0, 0, 2'd0, 3'd0));

        // R1 R2 R3 R4 R6 R9: four fetches across the 20-bit wrap
        for (int j = 0; j < 16; j++) begin
            tick();
            chk("R1", obs(), cyc(0, A + 20'(j / 4), 3'd3, j % 4));
            if (j % 4 == 2) chk("R4", {24'd0, bus_data_o}, {24'd0, mb(A + 20'(j / 4))});
        end
        for (int j = 0; j < 3; j++) begin
            tick();
            chk("R9", obs(), tx(0, A + 20'd3, 3'd0, 0, 0, 0, 2'd0, 3'd0));
        end

        // R7 queue order, R9 resume after removal
        take_i = 1'b1;
        take_first_i = 1'b1;
        #1;
        chk("R7", {22'd0, qstat_o, qbyte_o}, {22'd0, 2'd1, mb(A)});
        tick();
        chk("R9", obs(), tx(0, A + 20'd3, 3'd0, 0, 0, 0, 2'd0, 3'd0));
        take_first_i = 1'b0;
        #1;
        chk("R7", {22'd0, qstat_o, qbyte_o}, {22'd0, 2'd2, mb(A + 20'd1)});
        tick();
        chk("R9", obs(), cyc(0, A + 20'd4, 3'd3, 0));
        #1;
        chk("R7", {22'd0, qstat_o, qbyte_o}, {22'd0, 2'd2, mb(A + 20'd2)});
        tick();
        #1;
        chk("R7", {22'd0, qstat_o, qbyte_o}, {22'd0, 2'd2, mb(A + 20'd3)});
        tick();
        #1;
        chk("R7", {22'd0, qstat_o, qbyte_o}, 32'd0);
        tick();
        take_first_i = 1'b1;
        #1;
        chk("R7", {22'd0, qstat_o, qbyte_o}, {22'd0, 2'd1, mb(A + 20'd4)});
        tick();
        take_i = 1'b0;
        take_first_i = 1'b0;
        chk("R9", obs(), cyc(0, A + 20'd5, 3'd3, 0));

        // R10 flush during an active fetch
        flush_i = 1'b1;
        flush_addr_i = B;
        tick();
        flush_i = 1'b0;
        chk("R10", obs(), cyc(0, A + 20'd5, 3'd3, 1));
        tick();
        tick();
        chk("R10", obs(), cyc(0, A + 20'd5, 3'd3, 3));
        tick();
        chk("R10", obs(), cyc(0, B, 3'd3, 0));

        // R8 read waits for the fetch, then beats prefetch
        dreq_valid_i = 1'b1;
        dreq_write_i = 1'b0;
        dreq_seg_i = 3'd4;
        dreq_addr_i = D;
        for (int p = 1; p < 4; p++) begin
            tick();
            chk("R8", obs(), cyc(0, B, 3'd3, p));
        end
        for (int p = 0; p < 4; p++) begin
            tick();
            chk("R6", obs(), cyc(1, D, 3'd4, p));
            chk("R4", {23'd0, dreq_done_o, rdata_o}, {23'd0, p == 2, (p == 2) ? mb(D) : 8'd0});
            if (p == 2) dreq_valid_i = 1'b0;
        end
        tick();
        chk("R8", obs(), cyc(0, B + 20'd1, 3'd3, 0));
        take_i = 1'b1;
        take_first_i = 1'b1;
        #1;
        chk("R10", {22'd0, qstat_o, qbyte_o}, {22'd0, 2'd1, mb(B)});
        tick();
        take_i = 1'b0;
        take_first_i = 1'b0;

        // R5 write with the queue full
        for (int k = 0; k < 40; k++) begin
            if (tstate_o == 3'd0) break;
            tick();
        end
        chk("R9", obs(), tx(0, B + 20'd4, 3'd0, 0, 0, 0, 2'd0, 3'd0));
        dreq_valid_i = 1'b1;
        dreq_write_i = 1'b1;
        dreq_seg_i = 3'd1;
        dreq_addr_i = W;
        dreq_wdata_i = 8'hC3;
        for (int p = 0; p < 4; p++) begin
            tick();
            chk("R5", obs(), cyc(2, W, 3'd1, p));
            chk("R5", {23'd0, dreq_done_o, bus_data_o}, {23'd0, p == 2, (p == 2) ? 8'hC3 : 8'd0});
            if (p == 2) dreq_valid_i = 1'b0;
        end
        tick();
        chk("R2", obs(), tx(0, W, 3'd0, 0, 0, 0, 2'd0, 3'd0));
        tick();
        chk("R3", obs(), tx(0, W, 3'd0, 0, 0, 0, 2'd0, 3'd0));

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule